// File: doc/BRIEF.md
# State-Gated Timer Event Arbiter

This block decides, every clock cycle, which of a set of configurable timer events fire. The timer it serves has two counter halves, a low half and a high half, which can also be joined into one counter. Each event watches one match comparator output and one synchronized pin (an input or an output pin), and may also be qualified on the count direction. An event can fire only in the counter states that its state mask allows.

The block keeps one state register for each counter half. When events fire, the state of a half is updated by the highest-numbered firing event tied to that half. That event either loads its state value or adds it to the current state. The fired-event vector reports every firing event, so the action logic downstream can apply all of their other effects. Configuration comes in as flat parallel vectors, with event e occupying slice e of each field vector.

The states in play are the per-half state values (0 to 31; masks cover 0 to 7). Each cycle has three possible transitions per half: HOLD (no owned event fires), LOAD (the winning event has its load bit set) and ADD (the winning event has its load bit clear).

Top module: `tmr_evt_arbiter`

## Requirements
- R1: Event e can fire only when bit s of its 8-bit mask (ev_mask[e*8 +: 8]) is 1, where s is the current state of its counter half. A state of 8 or more matches no mask bit.
- R2: An event whose mask is all zeros never fires.
- R3: With unify at 0, ev_hsel[e] = 0 ties event e to the low half (state_l, match_l, halt_l, run_l, bidir_l, down_l) and 1 ties it to the high half. With unify at 1, ev_hsel is ignored, every event uses the low half, and state_h holds.
- R4: The match term is match_x[ev_msel[e*4 +: 4]] of the event's half, and it is true only while that half's run input is 1.
- R5: The pin term reads pin ev_iopin[e*2 +: 2] from io_in when ev_iosel[e] = 0 and from io_out when it is 1. Condition code 00 = low, 01 = rise, 10 = fall, 11 = high. A rise or fall compares the current value with the value sampled at the previous clock edge, and that previous value is 0 out of reset.
- R6: Combine code ev_comb[e*2 +: 2] selects the event condition: 00 = match OR pin, 01 = match only, 10 = pin only, 11 = match AND pin.
- R7: When the half's bidir input is 1, direction code ev_dirq[e*2 +: 2] of 01 requires down = 0 and 10 requires down = 1. Codes 00 and 11, and any code while bidir is 0, do not restrict firing.
- R8: No event tied to a half whose halt input is 1 fires.
- R9: At a clock edge, each half's state takes the result of the highest-numbered firing event tied to it. With ev_stload[e] = 1 the result is ev_stval[e*5 +: 5]; with ev_stload[e] = 0 it is the current state plus that value, modulo 32.
- R10: Both states are 0 after reset. A half with no firing event tied to it keeps its state.
- R11: ev_fire[e] is 1 in the same cycle for every event whose conditions hold, whichever event sets the state.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| unify | input | 1 | Join the two halves into one counter |
| halt_l | input | 1 | Low half halted |
| halt_h | input | 1 | High half halted |
| run_l | input | 1 | Low half running |
| run_h | input | 1 | High half running |
| bidir_l | input | 1 | Low half counts in both directions |
| bidir_h | input | 1 | High half counts in both directions |
| down_l | input | 1 | Low half counting down |
| down_h | input | 1 | High half counting down |
| match_l | input | NMATCH | Low half comparator outputs |
| match_h | input | NMATCH | High half comparator outputs |
| io_in | input | NIO | Synchronized input pins |
| io_out | input | NIO | Current output pin values |
| ev_mask | input | NEVT*MSKW | Per-event state masks |
| ev_msel | input | NEVT*MSW | Per-event match select |
| ev_hsel | input | NEVT | Per-event half select |
| ev_iosel | input | NEVT | Per-event pin source (0 input, 1 output) |
| ev_iopin | input | NEVT*IOW | Per-event pin index |
| ev_iocond | input | NEVT*2 | Per-event pin condition code |
| ev_comb | input | NEVT*2 | Per-event combine code |
| ev_dirq | input | NEVT*2 | Per-event direction code |
| ev_stval | input | NEVT*STW | Per-event state value |
| ev_stload | input | NEVT | Per-event load (1) or add (0) |
| ev_fire | output | NEVT | Events firing this cycle |
| state_l | output | STW | Low half state |
| state_h | output | STW | High half state |

## Verification
The hardest case to reach from the ports is several events on the same half firing in one cycle while they disagree on load versus add and on the value. Only this case shows whether the highest index wins and whether the other events are still reported. The stimulus gets there with phases that open every mask and set the pin condition to high on random pins, so that many events fire at once. Load bits are biased on, so the states keep coming back into the 0 to 7 window that the masks cover.

// File: rtl/evtarb_pkg.sv
package evtarb_pkg;
    typedef enum logic [1:0] {
        CMB_OR    = 2'b00,
        CMB_MATCH = 2'b01,
        CMB_PIN   = 2'b10,
        CMB_AND   = 2'b11
    } comb_e;

    typedef enum logic [1:0] {
        PIN_LOW  = 2'b00,
        PIN_RISE = 2'b01,
        PIN_FALL = 2'b10,
        PIN_HIGH = 2'b11
    } pin_e;

    typedef enum logic [1:0] {
        DIR_ANY  = 2'b00,
        DIR_UP   = 2'b01,
        DIR_DOWN = 2'b10,
        DIR_ANY2 = 2'b11
    } dirq_e;
endpackage

// File: rtl/evtarb_cond.sv
module evtarb_cond
    import evtarb_pkg::*;
#(
    parameter int MSKW   = 8,
    parameter int STW    = 5,
    parameter int NMATCH = 16,
    parameter int NIO    = 4,
    localparam int MIW   = $clog2(MSKW),
    localparam int MSW   = $clog2(NMATCH),
    localparam int IOW   = $clog2(NIO)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [STW-1:0]    st,
    input  logic              halted,
    input  logic              running,
    input  logic              bidir,
    input  logic              down,
    input  logic [NMATCH-1:0] match,
    input  logic [NIO-1:0]    in_now,
    input  logic [NIO-1:0]    in_was,
    input  logic [NIO-1:0]    out_now,
    input  logic [NIO-1:0]    out_was,
    input  logic [MSKW-1:0]   mask,
    input  logic [MSW-1:0]    msel,
    input  logic              iosel,
    input  logic [IOW-1:0]    iopin,
    input  logic [1:0]        iocond,
    input  logic [1:0]        comb,
    input  logic [1:0]        dirq,
    output logic              fire
);
    logic mask_ok, mhit, now, was, phit, cond, dir_ok;

    always_comb begin
        mask_ok = (st < STW'(MSKW)) && mask[st[MIW-1:0]];
        mhit    = running && match[msel];
        now     = iosel ? out_now[iopin] : in_now[iopin];
        was     = iosel ? out_was[iopin] : in_was[iopin];

        unique case (pin_e'(iocond))
            PIN_LOW:  phit = !now;
            PIN_RISE: phit = now && !was;
            PIN_FALL: phit = !now && was;
            PIN_HIGH: phit = now;
            default:  phit = 1'b0;
        endcase

        unique case (comb_e'(comb))
            CMB_OR:    cond = mhit || phit;
            CMB_MATCH: cond = mhit;
            CMB_PIN:   cond = phit;
            CMB_AND:   cond = mhit && phit;
            default:   cond = 1'b0;
        endcase

        if (!bidir) begin
            dir_ok = 1'b1;
        end else begin
            unique case (dirq_e'(dirq))
                DIR_UP:   dir_ok = !down;
                DIR_DOWN: dir_ok = down;
                DIR_ANY, DIR_ANY2: dir_ok = 1'b1;
                default:  dir_ok = 1'b1;
            endcase
        end

        fire = mask_ok && !halted && cond && dir_ok;
    end

    // R2
    zero_mask_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (mask == '0) |-> !fire);

    // R8
    halted_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
        halted |-> !fire);

    // R4
    idle_match_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!running && comb == 2'b01) |-> !fire);
endmodule

// File: rtl/evtarb_next.sv
module evtarb_next #(
    parameter int NEVT = 8,
    parameter int STW  = 5
) (
    input  logic [NEVT-1:0]     hit,
    input  logic [NEVT*STW-1:0] stval,
    input  logic [NEVT-1:0]     stload,
    input  logic [STW-1:0]      cur,
    output logic [STW-1:0]      nxt
);
    always_comb begin
        nxt = cur;
        for (int e = 0; e < NEVT; e++) begin
            if (hit[e]) begin
                nxt = stload[e] ? stval[e*STW +: STW] : cur + stval[e*STW +: STW];
            end
        end
    end
endmodule

// File: rtl/tmr_evt_arbiter.sv
module tmr_evt_arbiter #(
    parameter int NEVT   = 8,
    parameter int MSKW   = 8,
    parameter int STW    = 5,
    parameter int NMATCH = 16,
    parameter int NIO    = 4,
    localparam int MSW   = $clog2(NMATCH),
    localparam int IOW   = $clog2(NIO)
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 unify,
    input  logic                 halt_l,
    input  logic                 halt_h,
    input  logic                 run_l,
    input  logic                 run_h,
    input  logic                 bidir_l,
    input  logic                 bidir_h,
    input  logic                 down_l,
    input  logic                 down_h,
    input  logic [NMATCH-1:0]    match_l,
    input  logic [NMATCH-1:0]    match_h,
    input  logic [NIO-1:0]       io_in,
    input  logic [NIO-1:0]       io_out,
    input  logic [NEVT*MSKW-1:0] ev_mask,
    input  logic [NEVT*MSW-1:0]  ev_msel,
    input  logic [NEVT-1:0]      ev_hsel,
    input  logic [NEVT-1:0]      ev_iosel,
    input  logic [NEVT*IOW-1:0]  ev_iopin,
    input  logic [NEVT*2-1:0]    ev_iocond,
    input  logic [NEVT*2-1:0]    ev_comb,
    input  logic [NEVT*2-1:0]    ev_dirq,
    input  logic [NEVT*STW-1:0]  ev_stval,
    input  logic [NEVT-1:0]      ev_stload,
    output logic [NEVT-1:0]      ev_fire,
    output logic [STW-1:0]       state_l,
    output logic [STW-1:0]       state_h
);
    logic [NIO-1:0]  in_q, out_q;
    logic [STW-1:0]  st_l, st_h, nx_l, nx_h;
    logic [NEVT-1:0] side_h, fire;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            in_q  <= '0;
            out_q <= '0;
            st_l  <= '0;
            st_h  <= '0;
        end else begin
            in_q  <= io_in;
            out_q <= io_out;
            st_l  <= nx_l;
            st_h  <= nx_h;
        end
    end

    for (genvar e = 0; e < NEVT; e++) begin : g_evt
        assign side_h[e] = !unify && ev_hsel[e];

        evtarb_cond #(
            .MSKW(MSKW), .STW(STW), .NMATCH(NMATCH), .NIO(NIO)
        ) u_cond (
            .clk     (clk),
            .rst_n   (rst_n),
            .st      (side_h[e] ? st_h    : st_l),
            .halted  (side_h[e] ? halt_h  : halt_l),
            .running (side_h[e] ? run_h   : run_l),
            .bidir   (side_h[e] ? bidir_h : bidir_l),
            .down    (side_h[e] ? down_h  : down_l),
            .match   (side_h[e] ? match_h : match_l),
            .in_now  (io_in),
            .in_was  (in_q),
            .out_now (io_out),
            .out_was (out_q),
            .mask    (ev_mask[e*MSKW +: MSKW]),
            .msel    (ev_msel[e*MSW +: MSW]),
            .iosel   (ev_iosel[e]),
            .iopin   (ev_iopin[e*IOW +: IOW]),
            .iocond  (ev_iocond[e*2 +: 2]),
            .comb    (ev_comb[e*2 +: 2]),
            .dirq    (ev_dirq[e*2 +: 2]),
            .fire    (fire[e])
        );
    end

    evtarb_next #(.NEVT(NEVT), .STW(STW)) u_next_l (
        .hit    (fire & ~side_h),
        .stval  (ev_stval),
        .stload (ev_stload),
        .cur    (st_l),
        .nxt    (nx_l)
    );

    evtarb_next #(.NEVT(NEVT), .STW(STW)) u_next_h (
        .hit    (fire & side_h),
        .stval  (ev_stval),
        .stload (ev_stload),
        .cur    (st_h),
        .nxt    (nx_h)
    );

    assign ev_fire = fire;
    assign state_l = st_l;
    assign state_h = st_h;

    // R10
    hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (fire == '0) |=> ($stable(st_l) && $stable(st_h)));

    // R3
    unify_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        unify |=> $stable(st_h));

    // R9
    top_load_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (fire[NEVT-1] && !side_h[NEVT-1] && ev_stload[NEVT-1])
        |=> (st_l == $past(ev_stval[(NEVT-1)*STW +: STW])));
endmodule

// File: tb/tmr_evt_arbiter_test.sv
module tmr_evt_arbiter_test;
    logic clk = 1'b0;
    logic rst_n = 1'b0;
    always #10 clk = ~clk;

    logic unify = 0, halt_l = 0, halt_h = 0, run_l = 0, run_h = 0;
    logic bidir_l = 0, bidir_h = 0, down_l = 0, down_h = 0;
    logic [15:0] match_l = 0, match_h = 0;
    logic [3:0]  io_in = 0, io_out = 0;
    logic [7:0]  c_mask [8];
    logic [3:0]  c_msel [8];
    logic [1:0]  c_iopin [8], c_iocond [8], c_comb [8], c_dirq [8];
    logic [4:0]  c_stval [8];
    logic [7:0]  c_hsel, c_iosel, c_stload;

    logic [63:0] ev_mask;
    logic [31:0] ev_msel;
    logic [15:0] ev_iopin, ev_iocond, ev_comb, ev_dirq;
    logic [39:0] ev_stval;
    logic [7:0]  ev_fire;
    logic [4:0]  state_l, state_h;

    for (genvar e = 0; e < 8; e++) begin : g_pack
        assign ev_mask[e*8 +: 8]   = c_mask[e];
        assign ev_msel[e*4 +: 4]   = c_msel[e];
        assign ev_iopin[e*2 +: 2]  = c_iopin[e];
        assign ev_iocond[e*2 +: 2] = c_iocond[e];
        assign ev_comb[e*2 +: 2]   = c_comb[e];
        assign ev_dirq[e*2 +: 2]   = c_dirq[e];
        assign ev_stval[e*5 +: 5]  = c_stval[e];
    end

    tmr_evt_arbiter uut (
        .clk(clk), .rst_n(rst_n), .unify(unify),
        .halt_l(halt_l), .halt_h(halt_h), .run_l(run_l), .run_h(run_h),
        .bidir_l(bidir_l), .bidir_h(bidir_h), .down_l(down_l), .down_h(down_h),
        .match_l(match_l), .match_h(match_h), .io_in(io_in), .io_out(io_out),
        .ev_mask(ev_mask), .ev_msel(ev_msel), .ev_hsel(c_hsel), .ev_iosel(c_iosel),
        .ev_iopin(ev_iopin), .ev_iocond(ev_iocond), .ev_comb(ev_comb),
        .ev_dirq(ev_dirq), .ev_stval(ev_stval), .ev_stload(c_stload),
        .ev_fire(ev_fire), .state_l(state_l), .state_h(state_h)
    );

    int checks = 0, fails = 0;
    logic [4:0] m_l = 0, m_h = 0;
    logic [3:0] p_in = 0, p_out = 0;

    task automatic check(string tag, string what, int act, int exp);
        checks++;
        if (act != exp) begin
            fails++;
            $display("FAIL %s %s actual=%0h expected=%0h", tag, what, act, exp);
        end
    endtask

    function automatic logic m_fire(int e);
        logic sh, hl, rn, bd, dn, mh, now, was, ph, cond, dok, mok;
        logic [4:0] st;
        sh  = !unify && c_hsel[e];
        st  = sh ? m_h : m_l;
        hl  = sh ? halt_h : halt_l;
        rn  = sh ? run_h : run_l;
        bd  = sh ? bidir_h : bidir_l;
        dn  = sh ? down_h : down_l;
        mok = (st < 5'd8) && c_mask[e][st[2:0]];
        mh  = rn && (sh ? match_h[c_msel[e]] : match_l[c_msel[e]]);
        now = c_iosel[e] ? io_out[c_iopin[e]] : io_in[c_iopin[e]];
        was = c_iosel[e] ? p_out[c_iopin[e]] : p_in[c_iopin[e]];
        case (c_iocond[e])
            2'd0: ph = !now;
            2'd1: ph = now && !was;
            2'd2: ph = !now && was;
            default: ph = now;
        endcase
        case (c_comb[e])
            2'd0: cond = mh || ph;
            2'd1: cond = mh;
            2'd2: cond = ph;
            default: cond = mh && ph;
        endcase
        dok = !bd || c_dirq[e] == 2'd0 || c_dirq[e] == 2'd3 ||
              (c_dirq[e] == 2'd1 && !dn) || (c_dirq[e] == 2'd2 && dn);
        return mok && !hl && cond && dok;
    endfunction

    task automatic rnd(string tag);
        for (int e = 0; e < 8; e++) begin
            c_mask[e]   = 8'($urandom);
            c_msel[e]   = 4'($urandom);
            c_iopin[e]  = 2'($urandom);
            c_iocond[e] = 2'($urandom);
            c_comb[e]   = 2'($urandom);
            c_dirq[e]   = 2'($urandom);
            c_stval[e]  = 5'($urandom % 8);
            if (tag == "R2" && e % 2 == 0) c_mask[e] = 8'h00;
            if (tag == "R4") c_comb[e] = 2'd1;
            if (tag == "R5") c_comb[e] = 2'd2;
            if (tag == "R9" || tag == "R11") begin
                c_mask[e] = 8'hFF; c_comb[e] = 2'd0; c_iocond[e] = 2'd3;
            end
            if (tag == "R10") c_mask[e] = 8'h00;
        end
        c_hsel   = 8'($urandom);
        c_iosel  = 8'($urandom);
        c_stload = 8'($urandom) | 8'($urandom);
        unify    = 1'($urandom);
        halt_l   = ($urandom % 8) == 0;
        halt_h   = ($urandom % 8) == 0;
        run_l    = ($urandom % 4) != 0;
        run_h    = ($urandom % 4) != 0;
        bidir_l  = 1'($urandom);
        bidir_h  = 1'($urandom);
        down_l   = 1'($urandom);
        down_h   = 1'($urandom);
        match_l  = 16'($urandom);
        match_h  = 16'($urandom);
        io_in    = 4'($urandom);
        io_out   = 4'($urandom);
        if (tag == "R1") begin halt_l = 0; halt_h = 0; end
        if (tag == "R3") c_hsel = 8'hFF;
        if (tag == "R7") begin bidir_l = 1; bidir_h = 1; end
        if (tag == "R8") begin halt_l = 1'($urandom); halt_h = 1'($urandom); end
    endtask

    task automatic step(string tag);
        logic [7:0] ef;
        logic [4:0] nl, nh;
        @(negedge clk);
        rnd(tag);
        #5;
        for (int e = 0; e < 8; e++) ef[e] = m_fire(e);
        check(tag, "ev_fire", int'(ev_fire), int'(ef));
        check(tag, "state_l", int'(state_l), int'(m_l));
        check(tag, "state_h", int'(state_h), int'(m_h));
        nl = m_l;
        nh = m_h;
        for (int e = 0; e < 8; e++) begin
            if (ef[e]) begin
                if (!unify && c_hsel[e])
                    nh = c_stload[e] ? c_stval[e] : m_h + c_stval[e];
                else
                    nl = c_stload[e] ? c_stval[e] : m_l + c_stval[e];
            end
        end
        @(posedge clk);
        #1;
        m_l = nl; m_h = nh; p_in = io_in; p_out = io_out;
    endtask

    initial begin
        #(20 * 200000);
        fails++;
        $display("FAIL watchdog expired");
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end

    initial begin
        for (int e = 0; e < 8; e++) begin
            c_mask[e] = 0; c_msel[e] = 0; c_iopin[e] = 0; c_iocond[e] = 0;
            c_comb[e] = 0; c_dirq[e] = 0; c_stval[e] = 0;
        end
        c_hsel = 0; c_iosel = 0; c_stload = 0;
        repeat (3) @(posedge clk);
        #1 rst_n = 1'b1;
        @(negedge clk);
        // R10 reset state
        check("R10", "reset state_l", int'(state_l), 0);
        check("R10", "reset state_h", int'(state_h), 0);
        for (int i = 0; i < 400; i++) step("R1");
        for (int i = 0; i < 300; i++) step("R2");
        for (int i = 0; i < 300; i++) step("R3");
        for (int i = 0; i < 300; i++) step("R4");
        for (int i = 0; i < 300; i++) step("R5");
        for (int i = 0; i < 400; i++) step("R6");
        for (int i = 0; i < 300; i++) step("R7");
        for (int i = 0; i < 300; i++) step("R8");
        for (int i = 0; i < 400; i++) step("R9");
        for (int i = 0; i < 200; i++) step("R10");
        for (int i = 0; i < 400; i++) step("R11");
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end
endmodule